// File: doc/BRIEF.md
# Reshapeable Bit-Lane Memory

This block is an on-chip memory with a fixed number of bits that can be used in one of four shapes: full width, half width, quarter width or eighth width. Each step halves the data width and doubles the depth. With the default physical array of 256 rows of 8 bits, the four shapes are 256x8, 512x4, 1024x2 and 2048x1. With a 16-bit physical row they become 256x16 down to 2048x2. The shape is picked by a static two-bit input that the block samples only while reset is held.

Address, write data and write enable are captured in input registers on the input clock. The captured address is remapped onto the physical array: its low bits pick a row, and its upper bits pick a bit lane within that row. A write strobe derived from the registered enable updates only the bits of that lane. The selected lane is read back, right-aligned, and passes through an optional output register on a separate output clock.

A load port writes whole physical rows. It is used to fill the array before use, so that the block can serve as a ROM or a lookup table. Array contents survive reset, so data written in one shape can be read back in another.

Top module: `shape_ram`

## Requirements
- R1: While reset is held, rdata is all zeros. Reset does not clear the array contents.
- R2: mode_sel values map to shapes as follows: 0 is full width, 1 is half, 2 is quarter and 3 is eighth. The data width is PHYS_W>>mode, carried on the low bits of wdata and rdata. The rdata bits above that width read as zero.
- R3: addr[ROW_AW-1:0] selects the row. In mode m, the m bits addr[ROW_AW+m-1:ROW_AW] select lane k, which occupies physical bits [k*w+w-1 : k*w], where w is the data width. Higher addr bits are ignored.
- R4: A write in a narrow mode changes only the selected lane. The other bits of the row keep their values.
- R5: With the output register (OUT_REG=1), rdata shows the data at an address two clock edges after the edge that captures that address, and not before.
- R6: When a write and a read hit the same location in the same cycle, the read returns the old data. The new data is visible on the following read.
- R7: When load_en is high, the edge captures load_row and load_data, and the whole physical row is written on the next edge. A user write captured on the same edge is dropped.
- R8: Once reset is released, a change on mode_sel has no effect until the next reset.
- R9: With wen and load_en low, changes on wdata and addr leave the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock for the input registers and the array |
| clk_out | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset; also samples mode_sel |
| mode_sel | input | 2 | Shape select: 0 full, 1 half, 2 quarter, 3 eighth width |
| addr | input | ROW_AW+3 | Logical address (row in low bits, lane in upper bits) |
| wdata | input | PHYS_W | Write data, low PHYS_W>>mode bits used |
| wen | input | 1 | Write enable |
| load_en | input | 1 | Full-row preload enable |
| load_row | input | ROW_AW | Preload row index |
| load_data | input | PHYS_W | Preload row data |
| rdata | output | PHYS_W | Read data, right-aligned, zero-extended |

## Verification
The bench writes patterns in the eighth-width shape and reads them back after resetting into the full and half shapes. A design with reversed lane order or the wrong address split would return scrambled words. Narrow writes are followed by reads of the neighbouring lanes, which catches a write mask that clobbers a whole row. The read latency is sampled edge by edge, and a same-cycle write-then-read checks that old data comes out first; a write-first array or a missing pipeline stage would show the wrong value on the wrong edge. A load that collides with a user write, and a mode change without a reset, show whether the block lets the load win and ignores the late mode change.

// File: rtl/shape_ram_pkg.sv
package shape_ram_pkg;
  // Number of address bits that can select a lane (eighth width = 3 bits)
  localparam int LANE_FIELD = 3;

  typedef enum logic [1:0] {
    SHP_FULL    = 2'd0,
    SHP_HALF    = 2'd1,
    SHP_QUARTER = 2'd2,
    SHP_EIGHTH  = 2'd3
  } shape_e;
endpackage

// File: rtl/shape_ctrl.sv
module shape_ctrl
  import shape_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  output shape_e     shape_q
);
  always_ff @(posedge clk) begin
    if (rst) shape_q <= shape_e'(mode_sel);
  end

  // R8
  shape_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(shape_q));
endmodule

// File: rtl/shape_lane_map.sv
module shape_lane_map
  import shape_ram_pkg::*;
#(
  parameter int PHYS_W = 8,
  parameter int ROW_AW = 8
) (
  input  shape_e                         shape,
  input  logic [ROW_AW+LANE_FIELD-1:0]   addr,
  input  logic [PHYS_W-1:0]              wdata,
  output logic [ROW_AW-1:0]              row,
  output logic [LANE_FIELD-1:0]          lane,
  output logic [PHYS_W-1:0]              bit_mask,
  output logic [PHYS_W-1:0]              wide_data
);
  localparam int LB = $clog2(PHYS_W);

  always_comb begin
    int lw;
    logic [PHYS_W-1:0] tmp;
    lw   = PHYS_W >> shape;
    row  = addr[ROW_AW-1:0];
    lane = addr[ROW_AW +: LANE_FIELD] & ~(3'b111 << shape);
    tmp  = '0;
    for (int b = 0; b < PHYS_W; b++) begin
      bit_mask[b]  = ((b >> (LB - int'(shape))) == int'(lane));
      tmp          = wdata >> (b % lw);
      wide_data[b] = tmp[0];
    end
  end
endmodule

// File: rtl/shape_wr_pulse.sv
module shape_wr_pulse #(
  parameter int PHYS_W = 8,
  parameter int ROW_AW = 8
) (
  input  logic              wen_q,
  input  logic              load_q,
  input  logic [ROW_AW-1:0] user_row,
  input  logic [PHYS_W-1:0] user_mask,
  input  logic [PHYS_W-1:0] user_data,
  input  logic [ROW_AW-1:0] load_row_q,
  input  logic [PHYS_W-1:0] load_data_q,
  output logic              strobe,
  output logic [ROW_AW-1:0] wr_row,
  output logic [PHYS_W-1:0] wr_mask,
  output logic [PHYS_W-1:0] wr_data
);
  always_comb begin
    strobe = wen_q | load_q;
    if (load_q) begin
      wr_row  = load_row_q;
      wr_mask = '1;
      wr_data = load_data_q;
    end else begin
      wr_row  = user_row;
      wr_mask = user_mask;
      wr_data = user_data;
    end
  end
endmodule

// File: rtl/shape_bit_array.sv
module shape_bit_array #(
  parameter int PHYS_W = 8,
  parameter int ROWS   = 256,
  parameter int ROW_AW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [PHYS_W-1:0] wr_mask,
  input  logic [PHYS_W-1:0] wr_data,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [PHYS_W-1:0] rd_word
);
  logic [PHYS_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < PHYS_W; b++) begin
        if (wr_mask[b]) mem[wr_row][b] <= wr_data[b];
      end
    end
  end

  // read-first: the old row comes out when the same row is written
  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= mem[rd_row];
  end
endmodule

// File: rtl/shape_ram.sv
module shape_ram
  import shape_ram_pkg::*;
#(
  parameter int PHYS_W  = 8,
  parameter int ROWS    = 256,
  parameter bit OUT_REG = 1'b1,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int AW     = ROW_AW + LANE_FIELD
) (
  input  logic              clk_in,
  input  logic              clk_out,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic [AW-1:0]     addr,
  input  logic [PHYS_W-1:0] wdata,
  input  logic              wen,
  input  logic              load_en,
  input  logic [ROW_AW-1:0] load_row,
  input  logic [PHYS_W-1:0] load_data,
  output logic [PHYS_W-1:0] rdata
);
  shape_e                  shape_q;
  logic [AW-1:0]           addr_q;
  logic [PHYS_W-1:0]       wdata_q, load_data_q;
  logic [ROW_AW-1:0]       load_row_q;
  logic                    wen_q, load_q;
  logic [ROW_AW-1:0]       u_row, wr_row;
  logic [LANE_FIELD-1:0]   u_lane, lane_d;
  logic [PHYS_W-1:0]       u_mask, u_data, wr_mask, wr_data, rd_word, ext;
  logic                    strobe;

  shape_ctrl u_ctrl (.clk(clk_in), .rst(rst), .mode_sel(mode_sel), .shape_q(shape_q));

  // input capture stage
  always_ff @(posedge clk_in) begin
    addr_q      <= addr;
    wdata_q     <= wdata;
    load_row_q  <= load_row;
    load_data_q <= load_data;
    if (rst) begin
      wen_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      wen_q  <= wen;
      load_q <= load_en;
    end
  end

  shape_lane_map #(.PHYS_W(PHYS_W), .ROW_AW(ROW_AW)) u_map (
    .shape(shape_q), .addr(addr_q), .wdata(wdata_q),
    .row(u_row), .lane(u_lane), .bit_mask(u_mask), .wide_data(u_data));

  shape_wr_pulse #(.PHYS_W(PHYS_W), .ROW_AW(ROW_AW)) u_wp (
    .wen_q(wen_q), .load_q(load_q), .user_row(u_row), .user_mask(u_mask),
    .user_data(u_data), .load_row_q(load_row_q), .load_data_q(load_data_q),
    .strobe(strobe), .wr_row(wr_row), .wr_mask(wr_mask), .wr_data(wr_data));

  shape_bit_array #(.PHYS_W(PHYS_W), .ROWS(ROWS), .ROW_AW(ROW_AW)) u_arr (
    .clk(clk_in), .rst(rst), .we(strobe), .wr_row(wr_row), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_row(u_row), .rd_word(rd_word));

  // lane travels alongside the array read
  always_ff @(posedge clk_in) begin
    if (rst) lane_d <= '0;
    else     lane_d <= u_lane;
  end

  // lane extraction, right-aligned, zero-extended
  always_comb begin
    int lw;
    logic [PHYS_W-1:0] sh;
    lw = PHYS_W >> shape_q;
    sh = rd_word >> (int'(lane_d) * lw);
    for (int i = 0; i < PHYS_W; i++) ext[i] = (i < lw) ? sh[i] : 1'b0;
  end

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_out) begin
        if (rst) rdata <= '0;
        else     rdata <= ext;
      end
    end else begin : g_ocomb
      assign rdata = ext;
    end
  endgenerate

  // R7
  load_full_row_chk: assert property (@(posedge clk_in) disable iff (rst)
    ($past(load_en) && !$past(rst)) |-> (strobe && wr_mask == '1 && wr_row == $past(load_row)));

  // R4
  lane_only_chk: assert property (@(posedge clk_in) disable iff (rst)
    ($past(wen) && !$past(load_en) && !$past(rst)) |-> ($countones(wr_mask) == (PHYS_W >> shape_q)));

  // R9
  no_write_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!$past(wen) && !$past(load_en) && !$past(rst)) |-> !strobe);

  // R2
  upper_zero_chk: assert property (@(posedge clk_out) disable iff (rst)
    (rdata >> (PHYS_W >> shape_q)) == '0);
endmodule

// File: tb/shape_ram_tb.sv
`timescale 1ns/1ps
module shape_ram_tb;
  localparam int PW = 8;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode_sel;
  logic [RW+2:0] addr;
  logic [PW-1:0] wdata, load_data, rdata;
  logic          wen, load_en;
  logic [RW-1:0] load_row;

  int total = 0;
  int bad   = 0;
  int cur_mode = 0;
  logic [PW-1:0] ref_mem [256];

  always #2 clk = ~clk;

  shape_ram u_dut (
    .clk_in(clk), .clk_out(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr),
    .wdata(wdata), .wen(wen), .load_en(load_en), .load_row(load_row),
    .load_data(load_data), .rdata(rdata));

  function automatic logic [7:0] exp_rd(int m, int a);
    int w = PW >> m;
    int ln = (a >> RW) & ((1 << m) - 1);
    return 8'((ref_mem[a & 8'hFF] >> (ln * w)) & ((1 << w) - 1));
  endfunction

  function automatic void ref_wr(int m, int a, logic [7:0] d);
    int w = PW >> m;
    int ln = (a >> RW) & ((1 << m) - 1);
    for (int i = 0; i < w; i++) ref_mem[a & 8'hFF][ln * w + i] = d[i];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(int m);
    @(negedge clk);
    rst = 1'b1; mode_sel = 2'(m); wen = 1'b0; load_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata zero in reset", rdata, 8'h00);
    rst = 1'b0;
    cur_mode = m;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 11'(a); wdata = d; wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wen = 1'b0;
    ref_wr(cur_mode, a, d);
  endtask

  task automatic rd_chk(string tag, int a);
    @(negedge clk);
    addr = 11'(a); wen = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tag, rdata, exp_rd(cur_mode, a));
  endtask

  task automatic t_preload;
    for (int r = 0; r < 256; r++) begin
      @(negedge clk);
      load_en = 1'b1; load_row = 8'(r); load_data = 8'(r) ^ 8'h5A;
      ref_mem[r] = 8'(r) ^ 8'h5A;
    end
    @(negedge clk);
    load_en = 1'b0;
    rd_chk("R7 preload row0", 0);
    rd_chk("R7 preload row128", 128);
    rd_chk("R2 full width row255", 255);
  endtask

  task automatic t_lanes(int m);
    int lanes = 1 << m;
    int w = PW >> m;
    do_reset(m);
    for (int l = 0; l < lanes; l++) wr((l << RW) | 60, 8'((l * 5 + 3) & ((1 << w) - 1)));
    for (int l = 0; l < lanes; l++) rd_chk($sformatf("R3 lane map m%0d l%0d", m, l), (l << RW) | 60);
    wr((1 << RW) | 61, 8'hFF);
    rd_chk("R4 neighbour lane0 kept", 61);
    rd_chk("R4 written lane1", (1 << RW) | 61);
    rd_chk("R2 narrow upper zero", (1 << RW) | 61);
  endtask

  task automatic t_cross;
    do_reset(3);
    for (int l = 0; l < 8; l++) wr((l << RW) | 20, 8'((8'hB2 >> l) & 1));
    do_reset(0);
    rd_chk("R3 eighth->full row20", 20);
    chk("R3 full value", exp_rd(0, 20), 8'hB2);
    do_reset(1);
    rd_chk("R3 half lane1 row20", (1 << RW) | 20);
    chk("R3 half value", exp_rd(1, (1 << RW) | 20), 8'h0B);
  endtask

  task automatic t_latency;
    do_reset(0);
    rd_chk("R5 settle row10", 10);
    @(negedge clk);
    addr = 11'd11;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 still old after one stage", rdata, ref_mem[10]);
    @(posedge clk);
    @(negedge clk);
    chk("R5 new after two stages", rdata, ref_mem[11]);
  endtask

  task automatic t_rdw;
    logic [7:0] old = ref_mem[30];
    @(negedge clk);
    addr = 11'd30; wen = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wen = 1'b1; wdata = 8'h77;
    @(posedge clk);
    @(negedge clk);
    wen = 1'b0;
    ref_mem[30] = 8'h77;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 old data on collision", rdata, old);
    @(posedge clk);
    @(negedge clk);
    chk("R6 new data next read", rdata, 8'h77);
  endtask

  task automatic t_load_prio;
    @(negedge clk);
    addr = 11'd41; wdata = 8'h11; wen = 1'b1;
    load_en = 1'b1; load_row = 8'd40; load_data = 8'hEE;
    @(negedge clk);
    wen = 1'b0; load_en = 1'b0;
    ref_mem[40] = 8'hEE;
    rd_chk("R7 load row written", 40);
    rd_chk("R7 user write dropped", 41);
  endtask

  task automatic t_nowrite;
    @(negedge clk);
    wen = 1'b0; addr = 11'd50;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wdata = 8'(i * 37 + 1);
    end
    rd_chk("R9 no write when idle", 50);
  endtask

  task automatic t_mode_ignore;
    do_reset(0);
    wr(5, 8'hC3);
    @(negedge clk);
    mode_sel = 2'd3;
    rd_chk("R8 mode change ignored", 5);
    chk("R8 full word kept", exp_rd(0, 5), 8'hC3);
  endtask

  initial begin
    rst = 1'b1; mode_sel = 2'd0; addr = '0; wdata = '0; wen = 1'b0;
    load_en = 1'b0; load_row = '0; load_data = '0;
    do_reset(0);
    t_preload();
    t_lanes(1);
    t_lanes(2);
    t_lanes(3);
    t_cross();
    t_latency();
    t_rdw();
    t_load_prio();
    t_nowrite();
    t_mode_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule